// File: doc/BRIEF.md
# Low-Voltage Detect Control and Status Register

This block is the 8-bit control and status register that sits between the CPU and the low-voltage detect function of a chip. An external comparator delivers a detector input that is already synchronous to the block clock. The register qualifies that input with its enable bits and with the stop-mode indication. It holds a sticky detect flag and raises an interrupt request and a system reset request from that flag. It also drives the enable of the bandgap reference buffer. The analog comparator, the bandgap, the converter that uses it and the reset sequencer are all outside the block.

Two small state machines do the work. The lock machine has the states `LK_OPEN` and `LK_SEALED`. The first CPU write after reset takes it from `LK_OPEN` to `LK_SEALED` (transition *seal*), and `LK_SEALED` is held until reset. While the machine is open, a write loads all enables. Once it is sealed, a write changes only the interrupt enable and the bandgap enable, and can still acknowledge the flag. The flag machine has the states `FL_CLEAR` and `FL_SET`. The transition *detect* goes from `FL_CLEAR` to `FL_SET` on any cycle where the qualified detector input is high. The transition *release* goes from `FL_SET` back to `FL_CLEAR` on an acknowledge write, or when the detect enable is 0, but only in a cycle with no qualified detection. A detection therefore wins over an acknowledge in the same cycle.

The register is read through `rd_data` with this layout: bit 7 flag, bit 6 acknowledge (reads 0), bit 5 interrupt enable, bit 4 reset enable, bit 3 stop enable, bit 2 detect enable, bit 1 reserved (reads 0), bit 0 bandgap enable. A write updates the register at the next rising clock edge. Outputs and `rd_data` are driven from registers.

Top module: `lvd_ctrl`

## Requirements
- R1: After reset `rd_data` reads 8'h1C, meaning reset enable, stop enable and detect enable are 1 and every other bit is 0; `irq_o`, `rst_req_o` and `bg_buf_en_o` are 0.
- R2: A cycle with `lv_det_i`=1 while detection is qualified sets the flag (bit 7) at the next edge. The flag stays set after `lv_det_i` returns to 0, for as long as no acknowledge is written.
- R3: A write with bit 6=1 clears the flag at the next edge. If a qualified detection happens in that same cycle, the flag stays set.
- R4: Bit 6 and bit 1 of `rd_data` always read 0, whatever value was written to them.
- R5: `irq_o` is 1 exactly when the flag is set and the interrupt enable (bit 5) is 1.
- R6: `rst_req_o` is 1 exactly when the flag is set and both the reset enable (bit 4) and the detect enable (bit 2) are 1.
- R7: While `stop_mode_i`=1 and the stop enable (bit 3) is 0, `lv_det_i` does not set the flag. With stop enable 1, or when stop mode is inactive, it does.
- R8: Only the first write after reset changes bits 4, 3 and 2. Later writes leave those bits unchanged.
- R9: Bits 5 and 0 can be written by every write. `bg_buf_en_o` equals bit 0 and is not affected by any other bit.
- R10: With the detect enable at 0, the flag is cleared and `lv_det_i` cannot set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | Register read value |
| stop_mode_i | input | 1 | High while the chip is in stop mode |
| lv_det_i | input | 1 | Synchronous comparator output, high on low voltage |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | System reset request |
| bg_buf_en_o | output | 1 | Bandgap reference buffer enable |

## Verification
The bench builds the block with its default parameters, so the three safety enables come out of reset armed. That setting covers the reset request path, stop-mode detection and the open lock state with no setup. The bench reaches the other enable values through the first write after each reset: it seals the lock with enables at 0 to exercise stop gating, a disabled detector and a masked reset request. A later write then tries to restore the enables and must be ignored.

// File: rtl/lvd_ctrl_pkg.sv
package lvd_ctrl_pkg;

    localparam int REG_W = 8;

    // Bit positions of the register; software decodes these
    localparam int B_FLAG = 7;
    localparam int B_ACK  = 6;
    localparam int B_IE   = 5;
    localparam int B_RE   = 4;
    localparam int B_SE   = 3;
    localparam int B_DE   = 2;
    localparam int B_RSV  = 1;
    localparam int B_BG   = 0;

    typedef enum logic {
        LK_OPEN   = 1'b0,
        LK_SEALED = 1'b1
    } lock_state_e;

    typedef enum logic {
        FL_CLEAR = 1'b0,
        FL_SET   = 1'b1
    } flag_state_e;

    typedef struct packed {
        logic ie;
        logic re;
        logic se;
        logic de;
        logic bg;
    } lvd_cfg_t;

endpackage

// File: rtl/lvd_lock_fsm.sv
module lvd_lock_fsm
    import lvd_ctrl_pkg::*;
#(
    parameter bit INIT_RE = 1'b1,
    parameter bit INIT_SE = 1'b1,
    parameter bit INIT_DE = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  lvd_cfg_t wr_cfg,
    output lvd_cfg_t cfg_q,
    output lvd_cfg_t cfg_next
);

    localparam lvd_cfg_t CFG_RST = '{ie: 1'b0, re: INIT_RE, se: INIT_SE,
                                     de: INIT_DE, bg: 1'b0};

    lock_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and next configuration
    always_comb begin
        state_d  = state_q;
        cfg_next = cfg_q;
        unique case (state_q)
            LK_OPEN: begin
                if (wr_en) begin
                    cfg_next = wr_cfg;
                    state_d  = LK_SEALED;
                end
            end
            LK_SEALED: begin
                if (wr_en) begin
                    cfg_next.ie = wr_cfg.ie;
                    cfg_next.bg = wr_cfg.bg;
                end
            end
            default: state_d = LK_OPEN;
        endcase
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else begin
            cfg_q <= cfg_next;
        end
    end

endmodule

// File: rtl/lvd_flag_fsm.sv
module lvd_flag_fsm
    import lvd_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic det_i,
    input  logic stop_mode_i,
    input  logic de_next,
    input  logic se_q,
    input  logic ack_i,
    output logic flag_o
);

    flag_state_e state_q, state_d;
    logic        qual;

    assign qual = det_i & de_next & (~stop_mode_i | se_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FL_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_CLEAR: begin
                if (qual) state_d = FL_SET;
            end
            FL_SET: begin
                if (!qual && (ack_i || !de_next)) state_d = FL_CLEAR;
            end
            default: state_d = FL_CLEAR;
        endcase
    end

    always_comb begin
        flag_o = 1'b0;
        unique case (state_q)
            FL_CLEAR: flag_o = 1'b0;
            FL_SET:   flag_o = 1'b1;
            default:  flag_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/lvd_ctrl.sv
module lvd_ctrl
    import lvd_ctrl_pkg::*;
#(
    parameter bit INIT_RE = 1'b1,
    parameter bit INIT_SE = 1'b1,
    parameter bit INIT_DE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             stop_mode_i,
    input  logic             lv_det_i,
    output logic             irq_o,
    output logic             rst_req_o,
    output logic             bg_buf_en_o
);

    lvd_cfg_t wr_cfg, cfg_q, cfg_next;
    logic     flag;
    logic     ack;
    logic     unused_wr_bits;

    assign wr_cfg = '{ie: wr_data[B_IE], re: wr_data[B_RE], se: wr_data[B_SE],
                      de: wr_data[B_DE], bg: wr_data[B_BG]};
    assign ack    = wr_en & wr_data[B_ACK];
    assign unused_wr_bits = ^{wr_data[B_FLAG], wr_data[B_RSV]};

    lvd_lock_fsm #(
        .INIT_RE(INIT_RE),
        .INIT_SE(INIT_SE),
        .INIT_DE(INIT_DE)
    ) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_cfg  (wr_cfg),
        .cfg_q   (cfg_q),
        .cfg_next(cfg_next)
    );

    lvd_flag_fsm u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .det_i      (lv_det_i),
        .stop_mode_i(stop_mode_i),
        .de_next    (cfg_next.de),
        .se_q       (cfg_q.se),
        .ack_i      (ack),
        .flag_o     (flag)
    );

    always_comb begin
        rd_data         = '0;
        rd_data[B_FLAG] = flag;
        rd_data[B_IE]   = cfg_q.ie;
        rd_data[B_RE]   = cfg_q.re;
        rd_data[B_SE]   = cfg_q.se;
        rd_data[B_DE]   = cfg_q.de;
        rd_data[B_BG]   = cfg_q.bg;
    end

    assign irq_o       = flag & cfg_q.ie;
    assign rst_req_o   = flag & cfg_q.re & cfg_q.de;
    assign bg_buf_en_o = cfg_q.bg;

endmodule

// File: rtl/lvd_ctrl_chk.sv
module lvd_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       stop_mode_i,
    input logic       lv_det_i,
    input logic       irq_o,
    input logic       rst_req_o,
    input logic       bg_buf_en_o
);

    logic seen_wr;
    logic unused_chk;

    assign unused_chk = ^wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_wr <= 1'b0;
        else if (wr_en) seen_wr <= 1'b1;
    end

    // R2
    p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lv_det_i && !wr_en && rd_data[2] && (!stop_mode_i || rd_data[3])) |=> rd_data[7]);

    // R2
    p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7] && !wr_en) |=> rd_data[7]);

    // R3
    p_ack_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[6] && !lv_det_i) |=> !rd_data[7]);

    // R5
    p_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (rd_data[7] && rd_data[5]));

    // R6
    p_rst_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o == (rd_data[7] && rd_data[4] && rd_data[2]));

    // R7
    p_stop_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_mode_i && !rd_data[3] && !rd_data[7] && !wr_en) |=> !rd_data[7]);

    // R8
    p_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_wr && wr_en) |=> $stable(rd_data[4:2]));

    // R9
    p_bg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bg_buf_en_o == rd_data[0]);

    // R10
    p_de_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[2] |-> !rd_data[7]);

endmodule

bind lvd_ctrl lvd_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .stop_mode_i(stop_mode_i),
    .lv_det_i   (lv_det_i),
    .irq_o      (irq_o),
    .rst_req_o  (rst_req_o),
    .bg_buf_en_o(bg_buf_en_o)
);

// File: tb/lvd_ctrl_test.sv
`timescale 1ns/1ps
module lvd_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       stop_mode_i = 1'b0;
    logic       lv_det_i = 1'b0;
    logic       irq_o, rst_req_o, bg_buf_en_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lvd_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .stop_mode_i(stop_mode_i), .lv_det_i(lv_det_i),
        .irq_o(irq_o), .rst_req_o(rst_req_o), .bg_buf_en_o(bg_buf_en_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; lv_det_i = 1'b0; stop_mode_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one write; returns at the negedge after the capturing edge
    task automatic reg_wr(input logic [7:0] d, input logic det);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; lv_det_i = det;
        @(negedge clk);
        wr_en = 1'b0; lv_det_i = 1'b0;
    endtask

    task automatic det_pulse();
        @(negedge clk);
        lv_det_i = 1'b1;
        @(negedge clk);
        lv_det_i = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 rd_data", rd_data, 8'h1C);
        chk("R1 outputs", {5'b0, irq_o, rst_req_o, bg_buf_en_o}, 8'h00);
    endtask

    task automatic t_flag_ack();
        do_reset();
        det_pulse();
        @(negedge clk);
        chk("R2 sticky flag", rd_data, 8'h9C);
        chk("R6 reset request", {7'b0, rst_req_o}, 8'h01);
        chk("R5 irq masked", {7'b0, irq_o}, 8'h00);
        reg_wr(8'h5C, 1'b0);
        chk("R3 ack clears", rd_data, 8'h1C);
        det_pulse();
        reg_wr(8'h5C, 1'b1);
        chk("R3 set wins over ack", rd_data[7], 1'b1);
    endtask

    task automatic t_irq();
        do_reset();
        reg_wr(8'h3C, 1'b0);
        chk("R5 irq idle", {7'b0, irq_o}, 8'h00);
        det_pulse();
        chk("R5 irq raised", {7'b0, irq_o}, 8'h01);
        reg_wr(8'h00, 1'b0);
        chk("R5 irq off by enable", {7'b0, irq_o}, 8'h00);
        chk("R8 enables kept", rd_data, 8'h9C);
    endtask

    task automatic t_rst_masked();
        do_reset();
        reg_wr(8'h0C, 1'b0);
        det_pulse();
        chk("R6 flag set", rd_data, 8'h8C);
        chk("R6 reset masked", {7'b0, rst_req_o}, 8'h00);
    endtask

    task automatic t_stop();
        do_reset();
        stop_mode_i = 1'b1;
        det_pulse();
        chk("R7 stop with se=1 detects", rd_data[7], 1'b1);
        do_reset();
        reg_wr(8'h14, 1'b0);
        stop_mode_i = 1'b1;
        det_pulse();
        chk("R7 stop with se=0 blocks", rd_data, 8'h14);
        stop_mode_i = 1'b0;
        det_pulse();
        chk("R7 run mode detects", rd_data, 8'h94);
    endtask

    task automatic t_lock();
        do_reset();
        reg_wr(8'h00, 1'b0);
        chk("R8 first write loads", rd_data, 8'h00);
        reg_wr(8'h1C, 1'b0);
        chk("R8 later write ignored", rd_data, 8'h00);
        det_pulse();
        chk("R10 no detect when off", rd_data, 8'h00);
        reg_wr(8'h21, 1'b0);
        chk("R9 ie and bg written", rd_data, 8'h21);
        chk("R9 bg output", {7'b0, bg_buf_en_o}, 8'h01);
    endtask

    task automatic t_de_clear();
        do_reset();
        det_pulse();
        reg_wr(8'h00, 1'b0);
        chk("R10 flag cleared by de=0", rd_data, 8'h00);
    endtask

    task automatic t_reserved();
        do_reset();
        reg_wr(8'h1E, 1'b0);
        chk("R4 reserved reads 0", rd_data, 8'h1C);
        reg_wr(8'h5F, 1'b0);
        chk("R4 ack reads 0", rd_data, 8'h1D);
    endtask

    initial begin
        t_reset();
        t_flag_ack();
        t_irq();
        t_rst_masked();
        t_stop();
        t_lock();
        t_de_clear();
        t_reserved();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule